// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds a small set of replicated registers. Each register address stands for a grid of physical copies, one per hardware unit, with each copy named by a group index and an instance index. A selector register, at its own address, chooses which copy the next access touches and whether a write goes to every copy at once or to one copy only.

Reads always return exactly one copy: the one named by the selector's group and instance fields. A write with the broadcast bit set stores the value into every unit that is both present and powered. A write with the broadcast bit clear stores it only into the steered copy. Present and powered masks, one bit per unit, come from outside the block. An access steered to a unit that is missing, unpowered or outside the grid is terminated without error: a read gives zero and a write is dropped.

Software first programs the selector and then reads or writes the replicated address through the same simple register bus. Read data comes back one cycle after the request and is marked by a valid pulse.

Top module: `steerRegBank`

## Requirements
- R1: After reset the selector reads 0x8000_0001 (group 0, instance 1, broadcast bit set), every stored copy holds zero, and rdValid is low.
- R2: The selector sits at address 0x00. A write stores bit 31 (broadcast), bits 11:8 (group) and bits 3:0 (instance). All other bits read back as zero.
- R3: A write to replicated register k (address 0x10 + 4·k) while the broadcast bit is set updates every live copy of register k and no copy of any other register. A unit is live when both its present bit and its powered bit are set. The mask bit for a unit is group·4 + instance.
- R4: A write with the broadcast bit clear updates only the copy at the steered group and instance, and only if that unit is live.
- R5: A read of a replicated register returns the steered copy, whatever the state of the broadcast bit.
- R6: A read steered to a unit whose present or powered bit is clear returns zero.
- R7: A non-broadcast write steered to a unit that is not live is dropped. After the unit is enabled again, its copy still holds its older value.
- R8: A broadcast write leaves the copies of non-live units unchanged, and they keep their older value after being enabled again.
- R9: A group field of 4 or more, or an instance field of 4 or more, names no unit. Reads steered there return zero and writes steered there are dropped.
- R10: An access to any other address changes no state, and a read of such an address returns zero.
- R11: Every read request produces rdValid high with its data in the next cycle. A write produces no rdValid, and busRdata is zero whenever rdValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after a read request |
| presentMask | input | 16 | Per-unit present bit, index group·4 + instance |
| poweredMask | input | 16 | Per-unit powered bit, same indexing |

## Verification
Directed sequences come first. A broadcast write followed by a sweep of every group and instance shows that one write reaches all copies. A non-broadcast write read back at the target and at its neighbours shows that other copies stay untouched. Masking a unit before a write and unmasking it afterwards separates "dropped" from "stored but hidden", which a read taken while the unit is masked cannot do. Constrained random traffic then mixes selector values with out-of-grid fields, mask flips and stray addresses against a bench model of every copy.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int FIELD_W     = 4;
  localparam int GRP_LSB     = 8;
  localparam int INST_LSB    = 0;
  localparam int REG_IDX_W   = 4;

  typedef struct packed {
    logic                 selWr;
    logic                 selRd;
    logic                 regWr;
    logic                 regRd;
    logic [REG_IDX_W-1:0] regIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/steerCtrl.sv
module steerCtrl
  import steer_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_REGS   = 2,
  parameter int SEL_ADDR   = 0,
  parameter int REG_BASE   = 16,
  parameter int REG_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobe_t        strobe,
  output logic              rdValid
);
  always_comb begin
    strobe = '0;
    if (busValid) begin
      if (busAddr == ADDR_W'(SEL_ADDR)) begin
        strobe.selWr = busWrite;
        strobe.selRd = !busWrite;
      end
      for (int k = 0; k < NUM_REGS; k++) begin
        if (busAddr == ADDR_W'(REG_BASE + k * REG_STRIDE)) begin
          strobe.regWr  = busWrite;
          strobe.regRd  = !busWrite;
          strobe.regIdx = REG_IDX_W'(k);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= busValid && !busWrite;
  end
endmodule

// File: rtl/steerData.sv
module steerData
  import steer_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_INST   = 4,
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 2,
  localparam int NUM_UNITS = NUM_GROUPS * NUM_INST,
  localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int REG_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobe,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_UNITS-1:0] presentMask,
  input  logic [NUM_UNITS-1:0] poweredMask,
  output logic [DATA_W-1:0]    rdData,
  output logic [DATA_W-1:0]    selQ
);
  localparam int MC_BIT = DATA_W - 1;
  localparam logic [DATA_W-1:0] SEL_KEEP =
    (DATA_W'(1) << MC_BIT) |
    (DATA_W'((1 << FIELD_W) - 1) << GRP_LSB) |
    (DATA_W'((1 << FIELD_W) - 1) << INST_LSB);
  localparam logic [DATA_W-1:0] SEL_RESET = (DATA_W'(1) << MC_BIT) | DATA_W'(1);

  logic [NUM_UNITS-1:0] liveVec;
  logic [FIELD_W-1:0]   selGroup;
  logic [FIELD_W-1:0]   selInst;
  logic [2*FIELD_W-1:0] unitWide;
  logic [UNIT_W-1:0]    selUnit;
  logic                 inRange;
  logic                 selLive;
  logic                 mcast;
  logic [DATA_W-1:0]    store [NUM_REGS][NUM_UNITS];
  logic [DATA_W-1:0]    rdNext;

  assign liveVec  = presentMask & poweredMask;
  assign selGroup = selQ[GRP_LSB +: FIELD_W];
  assign selInst  = selQ[INST_LSB +: FIELD_W];
  assign mcast    = selQ[MC_BIT];
  assign inRange  = (32'(selGroup) < NUM_GROUPS) && (32'(selInst) < NUM_INST);
  assign unitWide = (2*FIELD_W)'(selGroup) * (2*FIELD_W)'(NUM_INST) + (2*FIELD_W)'(selInst);
  assign selUnit  = UNIT_W'(unitWide);
  assign selLive  = inRange && liveVec[selUnit];

  always_ff @(posedge clk) begin
    if (!rstN)             selQ <= SEL_RESET;
    else if (strobe.selWr) selQ <= wrData & SEL_KEEP;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : gReg
    for (genvar u = 0; u < NUM_UNITS; u++) begin : gUnit
      logic hitMe;
      assign hitMe = strobe.regWr && (strobe.regIdx == REG_IDX_W'(r)) && liveVec[u] &&
                     (mcast || (inRange && (selUnit == UNIT_W'(u))));
      always_ff @(posedge clk) begin
        if (!rstN)      store[r][u] <= '0;
        else if (hitMe) store[r][u] <= wrData;
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (strobe.selRd)
      rdNext = selQ;
    else if (strobe.regRd && selLive)
      rdNext = store[REG_W'(strobe.regIdx)][selUnit];
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end
endmodule

// File: rtl/steerRegBank.sv
module steerRegBank
  import steer_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_INST   = 4,
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 2,
  parameter int ADDR_W     = 8,
  parameter int SEL_ADDR   = 0,
  parameter int REG_BASE   = 16,
  parameter int REG_STRIDE = 4,
  localparam int NUM_UNITS = NUM_GROUPS * NUM_INST
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 rdValid,
  input  logic [NUM_UNITS-1:0] presentMask,
  input  logic [NUM_UNITS-1:0] poweredMask
);
  ctlStrobe_t        strobe;
  logic [DATA_W-1:0] selQ;

  steerCtrl #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .SEL_ADDR(SEL_ADDR),
    .REG_BASE(REG_BASE), .REG_STRIDE(REG_STRIDE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .strobe(strobe), .rdValid(rdValid)
  );

  steerData #(
    .NUM_GROUPS(NUM_GROUPS), .NUM_INST(NUM_INST), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWdata),
    .presentMask(presentMask), .poweredMask(poweredMask),
    .rdData(busRdata), .selQ(selQ)
  );
endmodule

// File: rtl/steerRegBankChk.sv
module steerRegBankChk #(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_INST   = 4,
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 2,
  parameter int ADDR_W     = 8,
  parameter int SEL_ADDR   = 0,
  parameter int REG_BASE   = 16,
  parameter int REG_STRIDE = 4,
  localparam int NUM_UNITS = NUM_GROUPS * NUM_INST
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busValid,
  input logic                 busWrite,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [DATA_W-1:0]    busRdata,
  input logic                 rdValid,
  input logic [NUM_UNITS-1:0] presentMask,
  input logic [NUM_UNITS-1:0] poweredMask,
  input logic [DATA_W-1:0]    selQ
);
  logic isReg;
  logic isSel;
  logic steerDead;
  int   grp;
  int   ins;

  always_comb begin
    isReg = 1'b0;
    for (int k = 0; k < NUM_REGS; k++)
      if (busAddr == ADDR_W'(REG_BASE + k * REG_STRIDE)) isReg = 1'b1;
    isSel = (busAddr == ADDR_W'(SEL_ADDR));
    grp = int'(selQ[11:8]);
    ins = int'(selQ[3:0]);
    if (grp >= NUM_GROUPS || ins >= NUM_INST) steerDead = 1'b1;
    else steerDead = !(presentMask[grp*NUM_INST+ins] && poweredMask[grp*NUM_INST+ins]);
  end

  AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> rdValid); // R11
  AST_NO_VALID_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && !busWrite) |=> !rdValid); // R11
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (busRdata == '0)); // R11
  AST_DEAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && isReg && steerDead) |=> (busRdata == '0)); // R6
  AST_STRAY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && !isReg && !isSel) |=> (busRdata == '0)); // R10
  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busWrite && isSel) |=> $stable(selQ)); // R2
endmodule

bind steerRegBank steerRegBankChk #(
  .NUM_GROUPS(NUM_GROUPS), .NUM_INST(NUM_INST), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
  .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .REG_BASE(REG_BASE), .REG_STRIDE(REG_STRIDE)
) uChk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
  .busRdata(busRdata), .rdValid(rdValid), .presentMask(presentMask),
  .poweredMask(poweredMask), .selQ(selQ)
);

// File: tb/sim_steerRegBank.sv
module sim_steerRegBank;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rdValid;
  logic [NU-1:0] pMask = '1;
  logic [NU-1:0] wMask = '1;

  int total = 0;
  int bad = 0;

  logic [31:0] mSel;
  logic [31:0] mStore [2][NU];

  always #(CLK_PERIOD/2) clk = ~clk;

  steerRegBank u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rdValid(rdValid),
    .presentMask(pMask), .poweredMask(wMask)
  );

  function automatic int regOf(logic [7:0] a);
    if (a == 8'h10) return 0;
    if (a == 8'h14) return 1;
    return -1;
  endfunction

  function automatic bit liveAt(int g, int i);
    if (g >= 4 || i >= 4) return 1'b0;
    return pMask[g*4+i] && wMask[g*4+i];
  endfunction

  function automatic logic [31:0] mRead(logic [7:0] a);
    int r = regOf(a);
    int g = int'(mSel[11:8]);
    int i = int'(mSel[3:0]);
    if (a == 8'h00) return mSel;
    if (r < 0) return 32'h0;
    if (!liveAt(g, i)) return 32'h0;
    return mStore[r][g*4+i];
  endfunction

  task automatic mApply(logic [7:0] a, logic [31:0] d);
    int r = regOf(a);
    int g = int'(mSel[11:8]);
    int i = int'(mSel[3:0]);
    if (a == 8'h00) mSel = d & 32'h8000_0F0F;
    else if (r >= 0) begin
      for (int gg = 0; gg < 4; gg++)
        for (int ii = 0; ii < 4; ii++)
          if (liveAt(gg, ii) && (mSel[31] || (gg == g && ii == i)))
            mStore[r][gg*4+ii] = d;
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    mApply(a, d);
    @(negedge clk);
    busValid = 1'b0;
    check("R11 no valid after write", 32'(rdValid), 32'd0);
  endtask

  task automatic rd(logic [7:0] a, string tag);
    logic [31:0] exp;
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    exp = mRead(a);
    @(negedge clk);
    busValid = 1'b0;
    check("R11 valid after read", 32'(rdValid), 32'd1);
    check(tag, busRdata, exp);
  endtask

  function automatic logic [7:0] pickAddr();
    case ($urandom % 5)
      0: return 8'h00;
      1: return 8'h10;
      2: return 8'h14;
      3: return 8'h08;
      default: return 8'h18;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mSel = 32'h8000_0001;
    for (int r = 0; r < 2; r++) for (int u = 0; u < NU; u++) mStore[r][u] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 rdValid low", 32'(rdValid), 32'd0);
    check("R1 selector reset", mSel, 32'h8000_0001);
    rd(8'h00, "R1 selector reads 80000001");
    rd(8'h10, "R1 reg0 copy zero");

    // broadcast write then sweep every copy
    wr(8'h10, 32'hA5A5_0001);
    for (int g = 0; g < 4; g++)
      for (int i = 0; i < 4; i++) begin
        wr(8'h00, 32'(g << 8) | 32'(i));
        rd(8'h10, "R3 broadcast reached copy");
        rd(8'h14, "R3 other register untouched");
      end

    // unicast to (2,3)
    wr(8'h00, 32'h0000_0203);
    wr(8'h14, 32'hBEEF_0203);
    rd(8'h14, "R4 unicast target");
    wr(8'h00, 32'h0000_0202);
    rd(8'h14, "R4 neighbour untouched");
    wr(8'h00, 32'h8000_0203);
    rd(8'h14, "R5 read with broadcast set");

    // terminated reads
    @(negedge clk); pMask[11] = 1'b0;
    rd(8'h14, "R6 absent unit reads zero");
    @(negedge clk); pMask[11] = 1'b1; wMask[11] = 1'b0;
    rd(8'h14, "R6 unpowered unit reads zero");
    @(negedge clk); wMask[11] = 1'b1;
    rd(8'h14, "R6 restored unit readable");

    // dropped unicast write
    @(negedge clk); wMask[5] = 1'b0;
    wr(8'h00, 32'h0000_0101);
    wr(8'h10, 32'hC0C0_C0C0);
    @(negedge clk); wMask[5] = 1'b1;
    rd(8'h10, "R7 dropped write keeps old value");

    // broadcast skipping an absent unit
    @(negedge clk); pMask[6] = 1'b0;
    wr(8'h00, 32'h8000_0000);
    wr(8'h10, 32'hD00D_0006);
    @(negedge clk); pMask[6] = 1'b1;
    wr(8'h00, 32'h0000_0102);
    rd(8'h10, "R8 skipped unit keeps old value");
    wr(8'h00, 32'h0000_0100);
    rd(8'h10, "R8 live unit got broadcast");

    // out-of-grid fields
    wr(8'h00, 32'h0000_0500);
    rd(8'h00, "R2 selector readback");
    rd(8'h10, "R9 group out of grid reads zero");
    wr(8'h10, 32'h1234_5678);
    wr(8'h00, 32'h0000_0007);
    rd(8'h10, "R9 instance out of grid reads zero");
    wr(8'h14, 32'h8765_4321);
    wr(8'h00, 32'h0000_0000);
    rd(8'h10, "R9 out-of-grid write dropped");

    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, "R2 reserved bits read zero");

    // stray address
    wr(8'h00, 32'h0000_0001);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, "R10 stray read zero");
    rd(8'h00, "R10 selector unchanged");
    rd(8'h10, "R10 copy unchanged");

    // random traffic
    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom % 8);
      if (op < 2)
        wr(8'h00, {1'($urandom), 19'h0, 4'($urandom % 6), 4'h0, 4'($urandom % 6)});
      else if (op < 4)
        wr(($urandom % 2) ? 8'h10 : 8'h14, $urandom);
      else if (op < 7)
        rd(pickAddr(), "R5 random read");
      else begin
        @(negedge clk);
        if ($urandom % 2) pMask[$urandom % NU] ^= 1'b1;
        else              wMask[$urandom % NU] ^= 1'b1;
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule